// File: doc/BRIEF.md
# Fractional Sample-Rate Strobe Generator

This block paces audio sample transfers. It turns one of two master reference tick streams into a sample-enable strobe whose average rate is a rational fraction of the chosen master. One tick stream belongs to the 44.1 kHz family and the other to the 48 kHz family. Each channel keeps an accumulator. On every tick of its chosen master, the accumulator grows by an increment and wraps modulo a modulus. Each wrap emits a one-cycle strobe. The average output rate is therefore master × inc / mod.

The block holds `NUM_CH` independent channels. With the default of two, channel 0 paces playback and channel 1 paces capture. A small write port sets up each channel through two registers. The family register picks the master tick stream. The rate word carries the increment in its low half and the 16-bit value (inc − mod − 1) in its high half. The block recovers the modulus from that word when the word is written. In normal use inc = 4 and mod = 4 × master / target, which gives target rates from 8 kHz to 48 kHz. The tick inputs are single-cycle pulses in the block's clock domain; producing them is not part of this block.

Top module: `fsr_strobe_gen`

## Requirements
- R1: After synchronous reset every `sample_stb` bit is 0, every channel selects the 48 kHz tick (family bit 0), and the increment is 0 with field 0 (modulus 0xFFFF). An unconfigured channel never strobes, whatever ticks arrive.
- R2: A write with `cfg_addr` = 0 sets the family bit of channel `cfg_chan` from `cfg_wdata[0]`. A value of 1 makes `tick_441` the channel's tick and 0 makes `tick_480` its tick. Ticks of the unselected family have no effect on the channel.
- R3: On each cycle in which the channel's selected tick is high, the accumulator adds the increment. If the sum is at least the modulus, the modulus is subtracted and the channel's `sample_stb` bit is 1 in the cycle after the tick. Otherwise the sum is kept and the bit is 0. Without a tick the bit is 0.
- R4: A write with `cfg_addr` = 1 loads the rate word. Bits 15:0 hold inc and bits 31:16 hold (inc − mod − 1) mod 2^16. The modulus is recovered as inc − field − 1 in 16-bit arithmetic. With inc = 4 and mod = 24, 600 selected ticks from a cleared accumulator give exactly 100 strobes.
- R5: The accumulator stays below the modulus whenever it is not 0. If inc ≥ mod, which includes a word that decodes to mod = 0, every selected tick strobes and the accumulator returns to 0.
- R6: A rate word write clears the channel's accumulator. A selected tick in the same cycle as that write is dropped, so there is no strobe in the next cycle.
- R7: Channels are independent. Writes addressed to one channel never change the strobes of another. Channel 0 is playback and channel 1 is capture.
- R8: A family write does not clear the accumulator. A tick arriving in the same cycle as a family write is judged against the family selected before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_chan | input | CH_W | Channel addressed by the write (0 playback, 1 capture) |
| cfg_addr | input | 1 | 0 = family register, 1 = rate word |
| cfg_wdata | input | 2*RATE_W | Write data |
| tick_441 | input | 1 | One-cycle tick of the 44.1 kHz master |
| tick_480 | input | 1 | One-cycle tick of the 48 kHz master |
| sample_stb | output | NUM_CH | One-cycle sample strobe per channel |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a rate-word write and a tick: the write must win, clear the accumulator and suppress the strobe. The second pair is a family write and a tick: the tick must still be judged against the old family. Both collisions appear in directed cases and in long random runs where writes and ticks of both families land on arbitrary cycles. A bench model with its own accumulator predicts every channel's strobe for every cycle, and each observed bit is compared with the prediction. Strobe counts over long tick runs confirm the average rate.

// File: rtl/fsr_pkg.sv
// Package: fsr_pkg
// Shared widths and encodings for the fractional sample-rate strobe generator.
// Assumes rate words are twice the accumulator width.
package fsr_pkg;
    localparam int unsigned RATE_W_DEF = 16;

    // Master family selected by a channel's family register.
    typedef enum logic {
        FAM_48K = 1'b0,
        FAM_44K = 1'b1
    } fam_e;

    // Register picked by cfg_addr.
    typedef enum logic {
        REG_FAMILY = 1'b0,
        REG_RATE   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/fsr_cfg_reg.sv
// Module: fsr_cfg_reg
// Holds one channel's family bit, increment and recovered modulus.
// The modulus is recovered once, when the rate word is loaded, as
// inc - field - 1 in W-bit arithmetic. Assumes writes are single-cycle.
module fsr_cfg_reg
    import fsr_pkg::*;
#(
    parameter int unsigned W = RATE_W_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_fam,
    input  logic           wr_rate,
    input  logic [2*W-1:0] wdata,
    output fam_e           fam,
    output logic [W-1:0]   inc,
    output logic [W-1:0]   modv
);
    logic [W-1:0] new_inc;
    logic [W-1:0] new_fld;
    logic [W-1:0] new_mod;

    // Split the rate word and recover the modulus from its packed form.
    always_comb begin
        new_inc = wdata[W-1:0];
        new_fld = wdata[2*W-1:W];
        new_mod = new_inc - new_fld - W'(1);
    end

    // Family register: updated only by a family write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fam <= FAM_48K;
        end else if (wr_fam) begin
            fam <= fam_e'(wdata[0]);
        end
    end

    // Rate registers: reset to inc 0 / field 0, which decodes to an all-ones modulus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc  <= '0;
            modv <= '1;
        end else if (wr_rate) begin
            inc  <= new_inc;
            modv <= new_mod;
        end
    end
endmodule

// File: rtl/fsr_accum.sv
// Module: fsr_accum
// Bresenham-style accumulator. On a tick it adds inc and wraps modulo modv,
// registering a one-cycle strobe on each wrap. A clear wins over a tick.
// If inc >= modv, every tick strobes and the accumulator returns to zero.
module fsr_accum #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clear,
    input  logic [W-1:0] inc,
    input  logic [W-1:0] modv,
    output logic         stb,
    output logic [W-1:0] acc
);
    logic [W:0]   sum;
    logic [W-1:0] rem;
    logic         over;
    logic         wrap;

    // Next-value arithmetic: widened sum, wrapped remainder, and the two compares.
    always_comb begin
        sum  = {1'b0, acc} + {1'b0, inc};
        rem  = acc + inc - modv;
        over = (inc >= modv);
        wrap = (sum >= {1'b0, modv});
    end

    // Accumulator and strobe update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            stb <= 1'b0;
        end else if (clear) begin
            acc <= '0;
            stb <= 1'b0;
        end else if (tick) begin
            if (over) begin
                acc <= '0;
                stb <= 1'b1;
            end else if (wrap) begin
                acc <= rem;
                stb <= 1'b1;
            end else begin
                acc <= sum[W-1:0];
                stb <= 1'b0;
            end
        end else begin
            stb <= 1'b0;
        end
    end
endmodule

// File: rtl/fsr_chan.sv
// Module: fsr_chan
// One rate channel: configuration registers, tick selection and accumulator.
// The tick is chosen by the family bit held before any same-cycle write.
module fsr_chan
    import fsr_pkg::*;
#(
    parameter int unsigned W = RATE_W_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_fam,
    input  logic           wr_rate,
    input  logic [2*W-1:0] wdata,
    input  logic           tick_441,
    input  logic           tick_480,
    output logic           stb,
    output logic [W-1:0]   acc,
    output logic [W-1:0]   modv,
    output logic           fam_bit
);
    fam_e         fam;
    logic [W-1:0] inc;
    logic         tick;

    fsr_cfg_reg #(.W(W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_fam (wr_fam),
        .wr_rate(wr_rate),
        .wdata  (wdata),
        .fam    (fam),
        .inc    (inc),
        .modv   (modv)
    );

    // Pick the master tick of the currently selected family.
    always_comb begin
        tick    = (fam == FAM_44K) ? tick_441 : tick_480;
        fam_bit = (fam == FAM_44K);
    end

    fsr_accum #(.W(W)) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .clear(wr_rate),
        .inc  (inc),
        .modv (modv),
        .stb  (stb),
        .acc  (acc)
    );
endmodule

// File: rtl/fsr_strobe_gen.sv
// Module: fsr_strobe_gen
// Top of the fractional sample-rate strobe generator: NUM_CH independent
// channels behind one write port. Channel 0 paces playback, 1 paces capture.
// Assumes tick inputs are one-cycle pulses synchronous to clk.
module fsr_strobe_gen
    import fsr_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned RATE_W = RATE_W_DEF,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CH_W-1:0]     cfg_chan,
    input  logic                cfg_addr,
    input  logic [2*RATE_W-1:0] cfg_wdata,
    input  logic                tick_441,
    input  logic                tick_480,
    output logic [NUM_CH-1:0]   sample_stb
);
    logic [NUM_CH-1:0]             wr_fam;
    logic [NUM_CH-1:0]             wr_rate;
    logic [NUM_CH-1:0][RATE_W-1:0] ch_acc;
    logic [NUM_CH-1:0][RATE_W-1:0] ch_mod;
    logic [NUM_CH-1:0]             ch_fam;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Decode the write port into per-channel register strobes.
        always_comb begin
            wr_fam[c]  = cfg_we && (cfg_chan == CH_W'(c)) && (cfg_addr == REG_FAMILY);
            wr_rate[c] = cfg_we && (cfg_chan == CH_W'(c)) && (cfg_addr == REG_RATE);
        end

        fsr_chan #(.W(RATE_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_fam  (wr_fam[c]),
            .wr_rate (wr_rate[c]),
            .wdata   (cfg_wdata),
            .tick_441(tick_441),
            .tick_480(tick_480),
            .stb     (sample_stb[c]),
            .acc     (ch_acc[c]),
            .modv    (ch_mod[c]),
            .fam_bit (ch_fam[c])
        );
    end
endmodule

// File: rtl/fsr_strobe_gen_chk.sv
// Module: fsr_strobe_gen_chk
// Property checker bound to fsr_strobe_gen. Observes ports and per-channel state.
module fsr_strobe_gen_chk #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned W      = 16,
    parameter int unsigned CH_W   = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic [CH_W-1:0]        cfg_chan,
    input logic                   cfg_addr,
    input logic                   tick_441,
    input logic                   tick_480,
    input logic [NUM_CH-1:0]      sample_stb,
    input logic [NUM_CH-1:0][W-1:0] ch_acc,
    input logic [NUM_CH-1:0][W-1:0] ch_mod,
    input logic [NUM_CH-1:0]      ch_fam
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_acc[c] == '0) || (ch_acc[c] < ch_mod[c])); // R5

        AST_STB_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            sample_stb[c] |-> $past(ch_fam[c] ? tick_441 : tick_480)); // R3

        AST_RATE_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr && (cfg_chan == CH_W'(c)))
            |=> ((ch_acc[c] == '0) && !sample_stb[c])); // R6

        AST_FAMILY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && !cfg_addr && (cfg_chan == CH_W'(c))) |=> $stable(ch_fam[c])); // R2
    end
endmodule

bind fsr_strobe_gen fsr_strobe_gen_chk #(
    .NUM_CH(NUM_CH),
    .W     (RATE_W),
    .CH_W  (CH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_chan  (cfg_chan),
    .cfg_addr  (cfg_addr),
    .tick_441  (tick_441),
    .tick_480  (tick_480),
    .sample_stb(sample_stb),
    .ch_acc    (ch_acc),
    .ch_mod    (ch_mod),
    .ch_fam    (ch_fam)
);

// File: tb/fsr_strobe_gen_tb.sv
// Bench for fsr_strobe_gen: directed corners plus seeded random traffic,
// every strobe compared with an independent per-channel model.
module fsr_strobe_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [0:0] cfg_chan;
    logic       cfg_addr;
    logic [31:0] cfg_wdata;
    logic       tick_441;
    logic       tick_480;
    logic [1:0] sample_stb;

    int checks = 0;
    int errors = 0;
    int m_acc[2];
    int m_inc[2];
    int m_mod[2];
    bit m_fam[2];
    int stb_cnt[2];

    always #4 clk = ~clk;

    fsr_strobe_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_chan  (cfg_chan),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .tick_441  (tick_441),
        .tick_480  (tick_480),
        .sample_stb(sample_stb)
    );

    // R4 word layout: bits 15:0 inc, bits 31:16 (inc - mod - 1) mod 2^16.
    function automatic logic [31:0] pack_word(int inc, int md);
        logic [15:0] f;
        f = 16'(inc - md - 1);
        return {f, 16'(inc)};
    endfunction

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check_val(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, update model, compare both strobes after the edge.
    task automatic step(bit we, bit ch, bit adr, logic [31:0] wd, int n_inc, int n_mod,
                        bit t441, bit t480);
        bit    exp[2];
        string tag[2];
        for (int c = 0; c < 2; c++) begin
            bit tk;
            bit hit;
            tk     = m_fam[c] ? t441 : t480;
            hit    = we && (ch == c[0]);
            exp[c] = 1'b0;
            if (hit && adr && tk)       tag[c] = "R6";
            else if (hit && !adr && tk) tag[c] = "R8";
            else if (we && !hit)        tag[c] = "R7";
            else                        tag[c] = "R3";
            if (hit && adr) begin
                m_acc[c] = 0;
                m_inc[c] = n_inc;
                m_mod[c] = n_mod & 16'hFFFF;
            end else if (tk) begin
                if (m_inc[c] >= m_mod[c]) begin
                    exp[c]   = 1'b1;
                    m_acc[c] = 0;
                end else if (m_acc[c] + m_inc[c] >= m_mod[c]) begin
                    exp[c]   = 1'b1;
                    m_acc[c] = m_acc[c] + m_inc[c] - m_mod[c];
                end else begin
                    m_acc[c] = m_acc[c] + m_inc[c];
                end
            end
            if (hit && !adr) m_fam[c] = wd[0];
        end
        cfg_we    = we;
        cfg_chan  = ch;
        cfg_addr  = adr;
        cfg_wdata = wd;
        tick_441  = t441;
        tick_480  = t480;
        @(posedge clk);
        #2;
        for (int c = 0; c < 2; c++) begin
            check_val(tag[c], int'(sample_stb[c]), int'(exp[c]), $sformatf("strobe ch%0d", c));
            if (sample_stb[c]) stb_cnt[c]++;
        end
        @(negedge clk);
    endtask

    task automatic wr_rate(bit ch, int inc, int md, bit t441, bit t480);
        step(1'b1, ch, 1'b1, pack_word(inc, md), inc, md, t441, t480);
    endtask

    task automatic wr_fam(bit ch, bit f, bit t441, bit t480);
        step(1'b1, ch, 1'b0, {31'b0, f}, 0, 0, t441, t480);
    endtask

    task automatic idle(bit t441, bit t480);
        step(1'b0, 1'b0, 1'b0, 32'h0, 0, 0, t441, t480);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cfg_we = 0; cfg_chan = 0; cfg_addr = 0; cfg_wdata = 0;
        tick_441 = 0; tick_480 = 0;
        for (int c = 0; c < 2; c++) begin
            m_acc[c] = 0; m_inc[c] = 0; m_mod[c] = 16'hFFFF; m_fam[c] = 0; stb_cnt[c] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_val("R1", int'(sample_stb), 0, "reset strobes");
        rst_n = 1'b1;

        // R1: unconfigured channels stay quiet under both tick streams.
        repeat (20) idle(1'b1, 1'b1);

        // R4: inc 4 / mod 24 on playback, 600 ticks -> 100 strobes.
        wr_rate(1'b0, 4, 24, 1'b0, 1'b0);
        stb_cnt[0] = 0; stb_cnt[1] = 0;
        repeat (600) idle(1'b0, 1'b1);
        check_val("R4", stb_cnt[0], 100, "strobes in 600 ticks");
        check_val("R7", stb_cnt[1], 0, "capture strobes while only playback set");

        // R2: capture on 44.1k family, inc 4 / mod 16; 48k ticks ignored.
        wr_fam(1'b1, 1'b1, 1'b0, 1'b0);
        wr_rate(1'b1, 4, 16, 1'b0, 1'b0);
        stb_cnt[1] = 0;
        repeat (40) idle(1'b0, 1'b1);
        check_val("R2", stb_cnt[1], 0, "capture strobes on unselected ticks");
        repeat (64) idle(1'b1, 1'b0);
        check_val("R2", stb_cnt[1], 16, "capture strobes on 64 selected ticks");

        // R5: inc >= mod strobes every tick; word decoding to mod 0 too.
        wr_rate(1'b0, 5, 3, 1'b0, 1'b0);
        stb_cnt[0] = 0;
        repeat (10) idle(1'b0, 1'b1);
        check_val("R5", stb_cnt[0], 10, "strobes with inc above mod");
        wr_rate(1'b0, 0, 0, 1'b0, 1'b0);
        stb_cnt[0] = 0;
        repeat (7) idle(1'b0, 1'b1);
        check_val("R5", stb_cnt[0], 7, "strobes with mod 0");

        // R6: write collides with the tick that would wrap.
        wr_rate(1'b0, 4, 8, 1'b0, 1'b0);
        idle(1'b0, 1'b1);
        wr_rate(1'b0, 4, 8, 1'b0, 1'b1);
        idle(1'b0, 1'b1);
        idle(1'b0, 1'b1);

        // R8: family write with a same-cycle tick uses the old family; acc kept.
        wr_fam(1'b0, 1'b1, 1'b1, 1'b1);
        idle(1'b1, 1'b0);
        wr_fam(1'b0, 1'b0, 1'b1, 1'b0);
        idle(1'b0, 1'b1);

        // Random traffic: ticks, writes and collisions on both channels.
        for (int i = 0; i < 6000; i++) begin
            bit a, b;
            a = ($urandom % 3) == 0;
            b = ($urandom % 3) == 0;
            if (($urandom % 40) == 0) begin
                bit ch;
                ch = 1'($urandom % 2);
                if (($urandom % 2) == 0) begin
                    int inc, md;
                    inc = 1 + int'($urandom % 8);
                    md  = (($urandom % 6) == 0) ? int'($urandom % 6) : 4 + int'($urandom % 60);
                    wr_rate(ch, inc, md, a, b);
                end else begin
                    wr_fam(ch, 1'($urandom % 2), a, b);
                end
            end else begin
                idle(a, b);
            end
        end
        report();
    end
endmodule